// File: doc/BRIEF.md
# Multicycle 32-bit integer processor core

This block is a small in-order processor core for the 32-bit base integer instruction set. It runs one instruction at a time through a fixed walk of states: fetch, execute (decode, register read and arithmetic), an optional memory step, and write-back. Instructions and data share one simple memory port. The core drives a request with a word address, a write flag, byte strobes and write data. The memory answers with read data and a ready pulse, and the core holds the request steady until that pulse arrives.

There are 32 general registers. Register zero is wired to zero. The core also keeps a program counter, which reset loads from a parameter. Every immediate is rebuilt from the bit layout of its own instruction format. The supported work is register and immediate arithmetic, shifts, comparisons, the six conditional branches, the two jumps, the upper-immediate forms, and byte, half and word loads and stores. Memory-ordering instructions retire as no-ops. Any encoding outside the supported set sets a sticky trap output and stops the core until the next reset.

Top module: `rv_core`

## Requirements
- R1: While `rst_n` is low, `mem_req` and `trap_illegal` are 0. The first request after reset is a fetch (`mem_we`=0) at address `RESET_ADDR`.
- R2: Register 0 always reads as zero. A write that names register 0 has no effect, so a later store of register 0 writes 0x00000000.
- R3: Register-register opcode 0110011 gives add and subtract (funct7 0100000 with funct3 000), signed and unsigned set-less-than, and, or, xor, and the left, logical right and arithmetic right shifts. Shifts use the low 5 bits of the second operand.
- R4: Opcode 0010011 applies the same operations with the sign-extended 12-bit immediate from bits [31:20]. The shift amount comes from bits [24:20], and bit 30 selects the arithmetic right shift.
- R5: Opcode 0110111 writes bits [31:12] followed by 12 zero bits. Opcode 0010111 writes that value plus the address of the instruction.
- R6: Opcode 1100011 takes a branch to PC plus the sign-extended offset {[31],[7],[30:25],[11:8],0} when funct3 names a true comparison: 000 equal, 001 not equal, 100 signed less, 101 signed greater-or-equal, 110 unsigned less, 111 unsigned greater-or-equal. Otherwise it falls through to PC+4.
- R7: Opcode 1101111 jumps to PC plus {[31],[19:12],[20],[30:21],0}. Opcode 1100111 jumps to rs1 plus the I immediate, with bit 0 cleared. Both write PC+4 to rd.
- R8: A store (0100011) goes to the word address with the low two bits cleared. funct3 000 sets one strobe at bit position addr[1:0] and copies the byte into every lane. funct3 001 sets strobes 0011 or 1100 by addr[1] and copies the half into both halves. funct3 010 sets all four strobes.
- R9: A load (0000011) picks the byte at addr[1:0] or the half at addr[1] from the read word. funct3 000 and 001 sign-extend it, 100 and 101 zero-extend it, and 010 returns the whole word.
- R10: Opcode 0001111 with funct3 000 or 001 changes no register and makes no data access. Execution continues at PC+4.
- R11: Any other opcode, or an undefined funct3/funct7 combination, sets `trap_illegal`. The trap stays set until reset, and no further memory request is made.
- R12: A request stays asserted with a stable address and write flag until `mem_ready`. Each instruction makes exactly one fetch, plus one data access if it is a load or store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request address (instruction address or word-aligned data address) |
| mem_wstrb | output | 4 | Byte write strobes |
| mem_wdata | output | 32 | Write data with lanes replicated |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Request completed |
| trap_illegal | output | 1 | Sticky illegal-instruction stop flag |

## Verification
The only visible state is what passes over the memory port, so every internal fault has to be traced to a store or a fetch address. A wrong register value, a wrong immediate or a wrong ALU result shows up in the write data or strobes of the next store that uses it. That is usually a few instructions later. A wrong program counter, or a wrong branch or jump decision, shows on `mem_addr` at the very next fetch. It then changes which stores happen at all, and the total access count. Decode faults that wrongly trap, or wrongly fail to trap, are visible within one instruction through `trap_illegal` and the access count.

// File: rtl/rvc_pkg.sv
package rvc_pkg;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;
  localparam int STRB_W = XLEN / 8;
  localparam int SHW    = $clog2(XLEN);

  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_ORDER  = 7'b0001111;

  typedef logic [XLEN-1:0] word_t;

  typedef enum logic [2:0] {
    ST_BOOT, ST_FETCH, ST_EXEC, ST_MEM, ST_WB, ST_HALT
  } state_e;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU,
    ALU_XOR, ALU_SRL, ALU_SRA, ALU_OR, ALU_AND, ALU_PASSB
  } alu_op_e;

  typedef struct packed {
    logic [REG_AW-1:0] rd;
    logic [REG_AW-1:0] rs1;
    logic [REG_AW-1:0] rs2;
    logic [2:0]        f3;
    word_t             imm;
    alu_op_e           alu_op;
    logic              a_pc;
    logic              b_imm;
    logic              wr_en;
    logic              is_load;
    logic              is_store;
    logic              is_branch;
    logic              is_jal;
    logic              is_jalr;
    logic              illegal;
  } ctrl_t;

  // Immediate builders, one per instruction format
  function automatic word_t imm_i(input word_t ir);
    return {{20{ir[31]}}, ir[31:20]};
  endfunction

  function automatic word_t imm_s(input word_t ir);
    return {{20{ir[31]}}, ir[31:25], ir[11:7]};
  endfunction

  function automatic word_t imm_b(input word_t ir);
    return {{19{ir[31]}}, ir[31], ir[7], ir[30:25], ir[11:8], 1'b0};
  endfunction

  function automatic word_t imm_u(input word_t ir);
    return {ir[31:12], 12'b0};
  endfunction

  function automatic word_t imm_j(input word_t ir);
    return {{11{ir[31]}}, ir[31], ir[19:12], ir[20], ir[30:21], 1'b0};
  endfunction

  function automatic alu_op_e alu_from_f3(input logic [2:0] f3, input logic alt,
                                          input logic reg_form);
    case (f3)
      3'b000:  return (alt && reg_form) ? ALU_SUB : ALU_ADD;
      3'b001:  return ALU_SLL;
      3'b010:  return ALU_SLT;
      3'b011:  return ALU_SLTU;
      3'b100:  return ALU_XOR;
      3'b101:  return alt ? ALU_SRA : ALU_SRL;
      3'b110:  return ALU_OR;
      default: return ALU_AND;
    endcase
  endfunction

  function automatic word_t alu_eval(input alu_op_e op, input word_t a, input word_t b);
    logic [SHW-1:0] sh;
    sh = b[SHW-1:0];
    case (op)
      ALU_ADD:   return a + b;
      ALU_SUB:   return a - b;
      ALU_SLL:   return a << sh;
      ALU_SLT:   return {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_SLTU:  return {{(XLEN-1){1'b0}}, (a < b)};
      ALU_XOR:   return a ^ b;
      ALU_SRL:   return a >> sh;
      ALU_SRA:   return word_t'($signed(a) >>> sh);
      ALU_OR:    return a | b;
      ALU_AND:   return a & b;
      default:   return b;
    endcase
  endfunction

  function automatic logic br_taken(input logic [2:0] f3, input word_t a, input word_t b);
    case (f3)
      3'b000:  return a == b;
      3'b001:  return a != b;
      3'b100:  return $signed(a) < $signed(b);
      3'b101:  return !($signed(a) < $signed(b));
      3'b110:  return a < b;
      3'b111:  return !(a < b);
      default: return 1'b0;
    endcase
  endfunction

  function automatic word_t ld_extract(input logic [2:0] f3, input word_t w,
                                       input logic [1:0] off);
    word_t by, hw;
    by = w >> {off, 3'b000};
    hw = w >> {off[1], 4'b0000};
    case (f3)
      3'b000:  return {{(XLEN-8){by[7]}}, by[7:0]};
      3'b100:  return {{(XLEN-8){1'b0}}, by[7:0]};
      3'b001:  return {{(XLEN-16){hw[15]}}, hw[15:0]};
      3'b101:  return {{(XLEN-16){1'b0}}, hw[15:0]};
      default: return w;
    endcase
  endfunction

  function automatic logic [STRB_W-1:0] st_strobe(input logic [2:0] f3, input logic [1:0] off);
    case (f3[1:0])
      2'b00:   return STRB_W'(4'b0001) << off;
      2'b01:   return STRB_W'(4'b0011) << {off[1], 1'b0};
      default: return '1;
    endcase
  endfunction

  function automatic word_t st_data(input logic [2:0] f3, input word_t d);
    case (f3[1:0])
      2'b00:   return {STRB_W{d[7:0]}};
      2'b01:   return {(STRB_W/2){d[15:0]}};
      default: return d;
    endcase
  endfunction
endpackage

// File: rtl/rvc_decode.sv
module rvc_decode
  import rvc_pkg::*;
(
  input  word_t ir,
  output ctrl_t ctrl
);
  logic [6:0] opc;
  logic [6:0] f7;
  logic [2:0] f3;

  assign opc = ir[6:0];
  assign f7  = ir[31:25];
  assign f3  = ir[14:12];

  always_comb begin
    ctrl        = '0;
    ctrl.rd     = ir[11:7];
    ctrl.rs1    = ir[19:15];
    ctrl.rs2    = ir[24:20];
    ctrl.f3     = f3;
    ctrl.alu_op = ALU_ADD;
    case (opc)
      OPC_OP: begin
        ctrl.wr_en  = 1'b1;
        ctrl.alu_op = alu_from_f3(f3, f7[5], 1'b1);
        if (f7 == 7'b0000000) ctrl.illegal = 1'b0;
        else if (f7 == 7'b0100000 && (f3 == 3'b000 || f3 == 3'b101)) ctrl.illegal = 1'b0;
        else ctrl.illegal = 1'b1;
      end
      OPC_OPIMM: begin
        ctrl.wr_en  = 1'b1;
        ctrl.b_imm  = 1'b1;
        ctrl.imm    = imm_i(ir);
        ctrl.alu_op = alu_from_f3(f3, ir[30], 1'b0);
        if (f3 == 3'b001) ctrl.illegal = (f7 != 7'b0000000);
        else if (f3 == 3'b101) ctrl.illegal = (f7 != 7'b0000000) && (f7 != 7'b0100000);
      end
      OPC_LUI: begin
        ctrl.wr_en  = 1'b1;
        ctrl.b_imm  = 1'b1;
        ctrl.imm    = imm_u(ir);
        ctrl.alu_op = ALU_PASSB;
      end
      OPC_AUIPC: begin
        ctrl.wr_en = 1'b1;
        ctrl.a_pc  = 1'b1;
        ctrl.b_imm = 1'b1;
        ctrl.imm   = imm_u(ir);
      end
      OPC_JAL: begin
        ctrl.wr_en  = 1'b1;
        ctrl.is_jal = 1'b1;
        ctrl.imm    = imm_j(ir);
      end
      OPC_JALR: begin
        ctrl.wr_en   = 1'b1;
        ctrl.is_jalr = 1'b1;
        ctrl.b_imm   = 1'b1;
        ctrl.imm     = imm_i(ir);
        ctrl.illegal = (f3 != 3'b000);
      end
      OPC_BRANCH: begin
        ctrl.is_branch = 1'b1;
        ctrl.imm       = imm_b(ir);
        ctrl.illegal   = (f3 == 3'b010) || (f3 == 3'b011);
      end
      OPC_LOAD: begin
        ctrl.wr_en   = 1'b1;
        ctrl.is_load = 1'b1;
        ctrl.b_imm   = 1'b1;
        ctrl.imm     = imm_i(ir);
        ctrl.illegal = (f3 == 3'b011) || (f3 == 3'b110) || (f3 == 3'b111);
      end
      OPC_STORE: begin
        ctrl.is_store = 1'b1;
        ctrl.b_imm    = 1'b1;
        ctrl.imm      = imm_s(ir);
        ctrl.illegal  = (f3 > 3'b010);
      end
      OPC_ORDER: begin
        ctrl.illegal = (f3 > 3'b001);
      end
      default: ctrl.illegal = 1'b1;
    endcase
    if (ctrl.illegal) ctrl.wr_en = 1'b0;
  end
endmodule

// File: rtl/rvc_regfile.sv
module rvc_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] wa,
  input  logic [W-1:0]            wd,
  input  logic [$clog2(NREG)-1:0] ra1,
  output logic [W-1:0]            rd1,
  input  logic [$clog2(NREG)-1:0] ra2,
  output logic [W-1:0]            rd2
);
  localparam int AW = $clog2(NREG);

  logic [W-1:0] bank [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign bank[g] = '0;
    end else begin : g_live
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else if (we && wa == AW'(g)) q <= wd;
      end
      assign bank[g] = q;
    end
  end

  assign rd1 = bank[ra1];
  assign rd2 = bank[ra2];
endmodule

// File: rtl/rvc_alu.sv
module rvc_alu
  import rvc_pkg::*;
(
  input  alu_op_e    op,
  input  word_t      a,
  input  word_t      b,
  input  logic [2:0] f3,
  input  word_t      cmp_a,
  input  word_t      cmp_b,
  output word_t      y,
  output logic       taken
);
  assign y     = alu_eval(op, a, b);
  assign taken = br_taken(f3, cmp_a, cmp_b);
endmodule

// File: rtl/rv_core.sv
module rv_core
  import rvc_pkg::*;
#(
  parameter logic [31:0] RESET_ADDR = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_wstrb,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ready,
  output logic        trap_illegal
);
  localparam int NREG = 1 << REG_AW;

  state_e state;
  word_t  pc, ir, res_q, npc_q, addr_q;
  ctrl_t  ctrl;

  logic [REG_AW-1:0] rf_ra1, rf_ra2;
  word_t             rf_rd1, rf_rd2;
  logic              rf_we;

  word_t alu_a, alu_b, alu_y;
  logic  br_ok;
  word_t link_pc, rel_pc, next_pc, exec_val;

  // Named events
  logic fetch_done, data_done, retire;
  assign fetch_done = (state == ST_FETCH) && mem_ready;
  assign data_done  = (state == ST_MEM) && mem_ready;
  assign retire     = (state == ST_WB);

  rvc_decode u_dec (
    .ir   (ir),
    .ctrl (ctrl)
  );

  assign rf_ra1 = ctrl.rs1;
  assign rf_ra2 = ctrl.rs2;
  assign rf_we  = retire && ctrl.wr_en;

  rvc_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .wa    (ctrl.rd),
    .wd    (res_q),
    .ra1   (rf_ra1),
    .rd1   (rf_rd1),
    .ra2   (rf_ra2),
    .rd2   (rf_rd2)
  );

  assign alu_a = ctrl.a_pc  ? pc       : rf_rd1;
  assign alu_b = ctrl.b_imm ? ctrl.imm : rf_rd2;

  rvc_alu u_alu (
    .op    (ctrl.alu_op),
    .a     (alu_a),
    .b     (alu_b),
    .f3    (ctrl.f3),
    .cmp_a (rf_rd1),
    .cmp_b (rf_rd2),
    .y     (alu_y),
    .taken (br_ok)
  );

  assign link_pc = pc + word_t'(4);
  assign rel_pc  = pc + ctrl.imm;

  always_comb begin
    if (ctrl.is_jal)                 next_pc = rel_pc;
    else if (ctrl.is_jalr)           next_pc = {alu_y[XLEN-1:1], 1'b0};
    else if (ctrl.is_branch && br_ok) next_pc = rel_pc;
    else                             next_pc = link_pc;
  end

  assign exec_val = (ctrl.is_jal || ctrl.is_jalr) ? link_pc : alu_y;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_BOOT;
      pc     <= RESET_ADDR;
      ir     <= '0;
      res_q  <= '0;
      npc_q  <= '0;
      addr_q <= '0;
    end else begin
      case (state)
        ST_BOOT: state <= ST_FETCH;
        ST_FETCH: begin
          if (fetch_done) begin
            ir    <= mem_rdata;
            state <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          if (ctrl.illegal) begin
            state <= ST_HALT;
          end else begin
            res_q  <= exec_val;
            npc_q  <= next_pc;
            addr_q <= alu_y;
            state  <= (ctrl.is_load || ctrl.is_store) ? ST_MEM : ST_WB;
          end
        end
        ST_MEM: begin
          if (data_done) begin
            if (ctrl.is_load) res_q <= ld_extract(ctrl.f3, mem_rdata, addr_q[1:0]);
            state <= ST_WB;
          end
        end
        ST_WB: begin
          pc    <= npc_q;
          state <= ST_FETCH;
        end
        ST_HALT: state <= ST_HALT;
        default: state <= ST_HALT;
      endcase
    end
  end

  assign mem_req      = (state == ST_FETCH) || (state == ST_MEM);
  assign mem_we       = (state == ST_MEM) && ctrl.is_store;
  assign mem_addr     = (state == ST_MEM) ? {addr_q[XLEN-1:2], 2'b00} : pc;
  assign mem_wstrb    = mem_we ? st_strobe(ctrl.f3, addr_q[1:0]) : '0;
  assign mem_wdata    = mem_we ? st_data(ctrl.f3, rf_rd2) : '0;
  assign trap_illegal = (state == ST_HALT);
endmodule

// File: rtl/rv_core_chk.sv
module rv_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [3:0]  mem_wstrb,
  input logic        mem_ready,
  input logic        trap_illegal,
  input logic [4:0]  rs1_idx,
  input logic [31:0] rs1_val
);
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R11
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_illegal |-> !mem_req);

  // R11
  trap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_illegal |=> trap_illegal);

  // R8
  strobe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> ($countones(mem_wstrb) == 1 || $countones(mem_wstrb) == 2 ||
                             $countones(mem_wstrb) == 4));

  // R2
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs1_idx == 5'd0) |-> (rs1_val == 32'd0));
endmodule

bind rv_core rv_core_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .mem_wstrb    (mem_wstrb),
  .mem_ready    (mem_ready),
  .trap_illegal (trap_illegal),
  .rs1_idx      (rf_ra1),
  .rs1_val      (rf_rd1)
);

// File: tb/rv_core_bench.sv
`timescale 1ns/1ps
module rv_core_bench;
  localparam logic [31:0] BOOT = 32'h0000_0000;
  localparam logic [6:0] K_R = 7'b0110011, K_I = 7'b0010011, K_LD = 7'b0000011,
                         K_LUI = 7'b0110111, K_AUI = 7'b0010111, K_JALR = 7'b1100111,
                         K_ORD = 7'b0001111;
  localparam logic [31:0] FILL = 32'hA5A5_A5A5;

  // {tag, byte address, expected word}
  localparam logic [95:0] VEC [23] = '{
    {"R3  ", 32'h200, 32'h0000_0002}, {"R3  ", 32'h204, 32'h0000_0008},
    {"R3  ", 32'h208, 32'h0000_0001}, {"R3  ", 32'h20C, 32'h0000_0000},
    {"R3  ", 32'h210, 32'hFFFF_FFFF}, {"R3  ", 32'h214, 32'h07FF_FFFF},
    {"R3  ", 32'h218, 32'h0000_00A0}, {"R5  ", 32'h21C, 32'h1234_5678},
    {"R8  ", 32'h220, 32'hA5A5_05A5}, {"R8  ", 32'h224, 32'hFFFD_A5A5},
    {"R9  ", 32'h228, 32'hFFFF_FFFD}, {"R9  ", 32'h22C, 32'h0000_00FD},
    {"R9  ", 32'h230, 32'hFFFF_FFFD}, {"R9  ", 32'h234, 32'h0000_1234},
    {"R6  ", 32'h238, 32'h0000_000A}, {"R7  ", 32'h23C, 32'h0000_009C},
    {"R5  ", 32'h240, 32'h0000_10A4}, {"R7  ", 32'h244, 32'h0000_00B4},
    {"R7  ", 32'h248, 32'h0000_0000}, {"R2  ", 32'h24C, 32'h0000_0000},
    {"R6  ", 32'h250, 32'hA5A5_A5A5}, {"R4  ", 32'h254, 32'h0000_00FA},
    {"R4  ", 32'h258, 32'hFFFF_FFFE}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_req, mem_we, trap_illegal;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_wstrb;
  logic [31:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;

  logic [31:0] mem [256];
  int lat = 1;
  int acc_cnt = 0;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  rv_core #(.RESET_ADDR(BOOT)) u_rv_core (
    .clk (clk), .rst_n (rst_n), .mem_req (mem_req), .mem_we (mem_we),
    .mem_addr (mem_addr), .mem_wstrb (mem_wstrb), .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata), .mem_ready (mem_ready), .trap_illegal (trap_illegal)
  );

  initial forever #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Memory model: answers after lat wait cycles, checks request stability
  initial begin
    int waited;
    logic [31:0] held;
    waited = 0;
    held = '0;
    forever begin
      @(negedge clk);
      if (mem_ready) begin
        mem_ready = 1'b0;
      end else if (mem_req) begin
        if (waited == 0) held = mem_addr;
        else check("R12 address held", mem_addr, held);
        if (waited < lat) begin
          waited++;
        end else begin
          if (mem_we) begin
            for (int b = 0; b < 4; b++)
              if (mem_wstrb[b]) mem[mem_addr[9:2]][b*8 +: 8] = mem_wdata[b*8 +: 8];
          end
          mem_rdata = mem[mem_addr[9:2]];
          mem_ready = 1'b1;
          acc_cnt++;
          waited = 0;
        end
      end
    end
  end

  // Bench-side instruction builders
  function automatic logic [31:0] e_r(input logic [6:0] f7, input logic [4:0] s2,
      input logic [4:0] s1, input logic [2:0] f3, input logic [4:0] d);
    return {f7, s2, s1, f3, d, K_R};
  endfunction
  function automatic logic [31:0] e_i(input logic [31:0] imm, input logic [4:0] s1,
      input logic [2:0] f3, input logic [4:0] d, input logic [6:0] op);
    return {imm[11:0], s1, f3, d, op};
  endfunction
  function automatic logic [31:0] e_s(input logic [31:0] imm, input logic [4:0] s2,
      input logic [4:0] s1, input logic [2:0] f3);
    return {imm[11:5], s2, s1, f3, imm[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] e_b(input logic [31:0] imm, input logic [4:0] s2,
      input logic [4:0] s1, input logic [2:0] f3);
    return {imm[12], imm[10:5], s2, s1, f3, imm[4:1], imm[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] e_u(input logic [19:0] up, input logic [4:0] d,
      input logic [6:0] op);
    return {up, d, op};
  endfunction
  function automatic logic [31:0] e_j(input logic [31:0] imm, input logic [4:0] d);
    return {imm[20], imm[10:1], imm[11], imm[19:12], d, 7'b1101111};
  endfunction

  task automatic load_main();
    for (int k = 0; k < 256; k++) mem[k] = FILL;
    mem[0]  = e_i(5, 0, 3'b000, 1, K_I);
    mem[1]  = e_i(-3, 0, 3'b000, 2, K_I);
    mem[2]  = e_r(7'h00, 2, 1, 3'b000, 3);
    mem[3]  = e_r(7'h20, 2, 1, 3'b000, 4);
    mem[4]  = e_s(32'h200, 3, 0, 3'b010);
    mem[5]  = e_s(32'h204, 4, 0, 3'b010);
    mem[6]  = e_r(7'h00, 1, 2, 3'b010, 5);
    mem[7]  = e_r(7'h00, 1, 2, 3'b011, 6);
    mem[8]  = e_s(32'h208, 5, 0, 3'b010);
    mem[9]  = e_s(32'h20C, 6, 0, 3'b010);
    mem[10] = e_r(7'h20, 1, 2, 3'b101, 7);
    mem[11] = e_r(7'h00, 1, 2, 3'b101, 8);
    mem[12] = e_r(7'h00, 1, 1, 3'b001, 9);
    mem[13] = e_s(32'h210, 7, 0, 3'b010);
    mem[14] = e_s(32'h214, 8, 0, 3'b010);
    mem[15] = e_s(32'h218, 9, 0, 3'b010);
    mem[16] = e_u(20'h12345, 10, K_LUI);
    mem[17] = e_i(32'h678, 10, 3'b000, 10, K_I);
    mem[18] = e_s(32'h21C, 10, 0, 3'b010);
    mem[19] = e_s(32'h221, 1, 0, 3'b000);
    mem[20] = e_s(32'h226, 2, 0, 3'b001);
    mem[21] = e_i(32'h226, 0, 3'b000, 11, K_LD);
    mem[22] = e_i(32'h226, 0, 3'b100, 12, K_LD);
    mem[23] = e_i(32'h226, 0, 3'b001, 13, K_LD);
    mem[24] = e_i(32'h21E, 0, 3'b101, 14, K_LD);
    mem[25] = e_s(32'h228, 11, 0, 3'b010);
    mem[26] = e_s(32'h22C, 12, 0, 3'b010);
    mem[27] = e_s(32'h230, 13, 0, 3'b010);
    mem[28] = e_s(32'h234, 14, 0, 3'b010);
    mem[29] = e_b(8, 1, 1, 3'b000);
    mem[30] = e_i(1, 0, 3'b000, 15, K_I);
    mem[31] = e_b(8, 1, 1, 3'b001);
    mem[32] = e_i(2, 15, 3'b000, 15, K_I);
    mem[33] = e_b(8, 1, 2, 3'b100);
    mem[34] = e_i(4, 15, 3'b000, 15, K_I);
    mem[35] = e_b(8, 1, 2, 3'b110);
    mem[36] = e_i(8, 15, 3'b000, 15, K_I);
    mem[37] = e_s(32'h238, 15, 0, 3'b010);
    mem[38] = e_j(8, 16);
    mem[39] = e_i(1, 0, 3'b000, 17, K_I);
    mem[40] = e_s(32'h23C, 16, 0, 3'b010);
    mem[41] = e_u(20'h00001, 18, K_AUI);
    mem[42] = e_s(32'h240, 18, 0, 3'b010);
    mem[43] = e_i(32'hB9, 0, 3'b000, 19, K_I);
    mem[44] = e_i(0, 19, 3'b000, 20, K_JALR);
    mem[45] = e_i(7, 0, 3'b000, 21, K_I);
    mem[46] = e_s(32'h244, 20, 0, 3'b010);
    mem[47] = e_s(32'h248, 21, 0, 3'b010);
    mem[48] = e_i(5, 1, 3'b000, 0, K_I);
    mem[49] = e_s(32'h24C, 0, 0, 3'b010);
    mem[50] = e_i(32'h0FF, 0, 3'b000, 0, K_ORD);
    mem[51] = e_b(8, 2, 1, 3'b101);
    mem[52] = e_s(32'h250, 1, 0, 3'b010);
    mem[53] = e_b(8, 2, 1, 3'b111);
    mem[54] = e_i(32'hFF, 1, 3'b100, 22, K_I);
    mem[55] = e_i(32'h401, 2, 3'b101, 23, K_I);
    mem[56] = e_s(32'h254, 22, 0, 3'b010);
    mem[57] = e_s(32'h258, 23, 0, 3'b010);
    mem[58] = 32'hFFFF_FFFF;
  endtask

  task automatic wait_trap(input string req);
    bit seen;
    seen = 1'b0;
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if (trap_illegal) begin
        seen = 1'b1;
        break;
      end
    end
    check(req, {31'b0, seen}, 32'd1);
  endtask

  task automatic start_core();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    acc_cnt = 0;
    check("R1 req low in reset", {31'b0, mem_req}, 32'd0);
    check("R1 trap low in reset", {31'b0, trap_illegal}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 first fetch request", {31'b0, mem_req}, 32'd1);
    check("R1 first fetch is read", {31'b0, mem_we}, 32'd0);
    check("R1 first fetch address", mem_addr, BOOT);
  endtask

  task automatic run_main(input int latency);
    int cnt_at_halt;
    lat = latency;
    load_main();
    start_core();
    wait_trap("R11 trap on undefined opcode");
    // 54 fetches and 26 data accesses; the ordering no-op adds none
    check("R10 total memory accesses", acc_cnt, 32'd80);
    for (int v = 0; v < 23; v++)
      check(string'(VEC[v][95:64]), mem[VEC[v][41:34]], VEC[v][31:0]);
    cnt_at_halt = acc_cnt;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (c == 11) begin
        check("R11 no request after trap", {31'b0, mem_req}, 32'd0);
        check("R11 trap stays set", {31'b0, trap_illegal}, 32'd1);
      end
    end
    check("R11 no access after trap", acc_cnt, cnt_at_halt);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    run_main(1);
    run_main(3);

    // Undefined funct7 on a shift: traps before the following store
    lat = 2;
    for (int k = 0; k < 256; k++) mem[k] = FILL;
    mem[0] = e_r(7'h20, 2, 1, 3'b001, 3);
    mem[1] = e_s(32'h260, 0, 0, 3'b010);
    start_core();
    wait_trap("R11 trap on bad funct7");
    repeat (5) @(negedge clk);
    check("R11 only the fetch happened", acc_cnt, 32'd1);
    check("R11 later store suppressed", mem[32'h260 >> 2], FILL);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule